// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by walking a two-level page table held in memory. A walk starts when a request is accepted while the walker is idle. The walker reads the outer-table entry picked by the upper index bits from a table whose base comes from a root register. That entry names the frame holding an inner table. The walker then reads the inner-table entry picked by the middle index bits. That entry names the target frame, which is joined with the untouched page offset.

Either read can return an entry whose valid bit is clear. The walk then stops, and the response reports a fault together with the level that failed. The walker has one memory read port with a valid/ready request channel and a response channel of arbitrary latency. It never has more than one read in flight. Each result is delivered as a single-cycle response pulse, after which the walker is ready again.

Top module: `pt_walker`

## Requirements
- R1: The logical address splits as outer index = bits 31:22, inner index = bits 21:12 and page offset = bits 11:0.
- R2: The first memory read of a walk goes to root_base + outer_index*4, using the root_base and address sampled when the request is accepted; later changes to those inputs do not affect the walk.
- R3: When the outer entry is valid, the second read goes to (outer entry bits 31:12, followed by twelve zero bits) + inner_index*4.
- R4: When both entries are valid, the response carries rsp_fault=0 and rsp_paddr = {inner entry bits 31:12, offset}. Entry bits 11:1 are ignored.
- R5: An outer entry with bit 0 clear ends the walk after exactly one read, with rsp_fault=1, rsp_fault_lvl=0 and rsp_paddr=0.
- R6: An inner entry with bit 0 clear ends the walk after exactly two reads, with rsp_fault=1, rsp_fault_lvl=1 and rsp_paddr=0.
- R7: rsp_valid is high for exactly one cycle per walk, and req_ready is high again in the following cycle.
- R8: req_ready is high only while idle. A req_valid raised while a walk is in progress starts no walk and causes no memory read.
- R9: A memory request keeps mem_req_valid high and mem_req_addr unchanged until mem_req_ready is seen.
- R10: At most one read is outstanding. A mem_rsp_valid that arrives while no accepted read is pending is ignored.
- R11: After reset, req_ready=1, mem_req_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| root_base | input | 32 | Physical byte address of the outer table |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |
| rsp_valid | output | 1 | One-cycle walk result strobe |
| rsp_paddr | output | 32 | Translated physical address, zero on fault |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 outer, 1 inner |

## Verification
Random walks use random addresses, random table placements and entries. Each entry is valid with seven chances in eight, and the unused entry bits are filled with noise. This tells full translations apart from faults at either level, and checks that the frame field alone drives the result. Memory ready stalls and response latencies of zero to several cycles show that request holding and the single outstanding read do not depend on timing. Directed cases exercise the address extremes (all-zero and all-one addresses, all-one frames), which show that the index and offset fields sit at the right bits. Other directed cases raise a request while a walk is busy, change the root and address inputs after acceptance, and inject stray memory responses. These show that nothing outside the accepted walk changes the reads or the result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      PW_IDLE  = 3'd0,
      PW_OUTER = 3'd1,
      PW_INNER = 3'd2,
      PW_DONE  = 3'd3,
      PW_FAULT = 3'd4
   } pw_state_e;

   localparam int PW_LEVELS = 2;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int LEVELS      = 2,
   parameter int PA_W        = 32,
   parameter int ENTRY_SHIFT = 2,
   localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] level,
   input  logic [PA_W-1:0]  table_base,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int PAD_W = PA_W - IDX_W - ENTRY_SHIFT;

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_bad_split
      $error("ptw_index_sel: address split does not cover VA_W");
   end
   if (PAD_W < 0) begin : g_bad_pad
      $error("ptw_index_sel: PA_W too small for scaled index");
   end

   logic [IDX_W-1:0] slice [LEVELS];

   // level 0 is the outermost table and takes the most significant index
   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slice[g] = vaddr[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
   end

   logic [IDX_W-1:0] idx;
   assign idx = slice[level];

   logic unused_offset;
   assign unused_offset = ^vaddr[OFF_W-1:0];

   if (PAD_W > 0) begin : g_pad
      assign entry_addr = table_base + {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
   end else begin : g_nopad
      assign entry_addr = table_base + {idx, {ENTRY_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
   parameter int PTE_W     = 32,
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int VALID_POS = 0,
   localparam int FRAME_W  = PA_W - OFF_W
) (
   input  logic [PTE_W-1:0]   pte,
   output logic               pte_valid,
   output logic [FRAME_W-1:0] frame
);
   localparam int FIELD_W = PTE_W - OFF_W;

   if (VALID_POS >= OFF_W) begin : g_bad_valid
      $error("ptw_pte_decode: valid flag must sit below the frame field");
   end

   assign pte_valid = pte[VALID_POS];

   if (FIELD_W >= FRAME_W) begin : g_trunc
      assign frame = pte[OFF_W +: FRAME_W];
   end else begin : g_zext
      assign frame = {{(FRAME_W - FIELD_W){1'b0}}, pte[PTE_W-1:OFF_W]};
   end

   logic unused_bits;
   assign unused_bits = ^pte;
endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   output logic mem_req_valid,
   output logic rsp_take
);
   logic pend_q;
   logic wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         if (issue)
            pend_q <= 1'b1;
         else if (pend_q && mem_req_ready)
            pend_q <= 1'b0;

         if (pend_q && mem_req_ready)
            wait_q <= 1'b1;
         else if (wait_q && mem_rsp_valid)
            wait_q <= 1'b0;
      end
   end

   assign mem_req_valid = pend_q;
   assign rsp_take      = wait_q & mem_rsp_valid;

   // R9: an offered read is held until taken
   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid);

   // R10: no new read is offered while one is in flight
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q |-> !mem_req_valid);

   // R10: the walker only issues into a free port
   a_r10_issue_free: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !pend_q && (!wait_q || mem_rsp_valid));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int IDX_W     = 10,
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int VALID_POS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  root_base,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fault,
   output logic             rsp_fault_lvl
);
   localparam int FRAME_W     = PA_W - OFF_W;
   localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

   if (PTE_W % 8 != 0) begin : g_bad_pte
      $error("pt_walker: entry width must be whole bytes");
   end
   if (VA_W != OFF_W + PW_LEVELS * IDX_W) begin : g_bad_va
      $error("pt_walker: VA_W must equal offset plus two index fields");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("pt_walker: PA_W must exceed the offset width");
   end

   pw_state_e         state_q, state_d;
   logic [VA_W-1:0]   vaddr_q;
   logic [PA_W-1:0]   tbase_q;
   logic [PA_W-1:0]   paddr_q;
   logic              flvl_q;
   logic              issue;
   logic              rsp_take;
   logic              pte_valid;
   logic [FRAME_W-1:0] frame;
   logic              lvl;

   assign lvl = (state_q == PW_INNER);

   ptw_index_sel #(
      .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(PW_LEVELS),
      .PA_W(PA_W), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_idx (
      .vaddr(vaddr_q), .level(lvl), .table_base(tbase_q), .entry_addr(mem_req_addr)
   );

   ptw_pte_decode #(
      .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W), .VALID_POS(VALID_POS)
   ) u_dec (
      .pte(mem_rsp_data), .pte_valid(pte_valid), .frame(frame)
   );

   ptw_mem_port u_port (
      .clk(clk), .rst_n(rst_n), .issue(issue), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_req_valid(mem_req_valid), .rsp_take(rsp_take)
   );

   always_comb begin
      state_d = state_q;
      issue   = 1'b0;
      case (state_q)
         PW_IDLE: if (req_valid) begin
            state_d = PW_OUTER;
            issue   = 1'b1;
         end
         PW_OUTER: if (rsp_take) begin
            if (pte_valid) begin
               state_d = PW_INNER;
               issue   = 1'b1;
            end else begin
               state_d = PW_FAULT;
            end
         end
         PW_INNER: if (rsp_take) state_d = pte_valid ? PW_DONE : PW_FAULT;
         PW_DONE:  state_d = PW_IDLE;
         PW_FAULT: state_d = PW_IDLE;
         default:  state_d = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PW_IDLE;
         vaddr_q <= '0;
         tbase_q <= '0;
         paddr_q <= '0;
         flvl_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         case (state_q)
            PW_IDLE: if (req_valid) begin
               vaddr_q <= req_vaddr;
               tbase_q <= root_base;
               paddr_q <= '0;
               flvl_q  <= 1'b0;
            end
            PW_OUTER: if (rsp_take) begin
               if (pte_valid) tbase_q <= {frame, {OFF_W{1'b0}}};
               else           flvl_q  <= 1'b0;
            end
            PW_INNER: if (rsp_take) begin
               if (pte_valid) paddr_q <= {frame, vaddr_q[OFF_W-1:0]};
               else           flvl_q  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign req_ready     = (state_q == PW_IDLE);
   assign rsp_valid     = (state_q == PW_DONE) || (state_q == PW_FAULT);
   assign rsp_fault     = (state_q == PW_FAULT);
   assign rsp_fault_lvl = flvl_q;
   assign rsp_paddr     = paddr_q;

   // R9: address does not move while the request waits
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

   // R7: single-cycle result followed by readiness
   a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);

   // R8: an accepted request makes the walker busy
   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid);

   // R5: invalid outer entry gives a level-0 fault next cycle
   a_r5_outer_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PW_OUTER) && rsp_take && !pte_valid |=>
         rsp_valid && rsp_fault && !rsp_fault_lvl && !mem_req_valid);

   // R6: invalid inner entry gives a level-1 fault next cycle
   a_r6_inner_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PW_INNER) && rsp_take && !pte_valid |=>
         rsp_valid && rsp_fault && rsp_fault_lvl);

   // R4: valid inner entry completes without fault
   a_r4_success: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PW_INNER) && rsp_take && pte_valid |=> rsp_valid && !rsp_fault);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [31:0] root_base;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        rsp_fault_lvl;

   always #5 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .root_base(root_base), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .rsp_fault_lvl(rsp_fault_lvl)
   );

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   logic [31:0] mem [logic [31:0]];
   logic [31:0] addr_log [$];
   int          max_lat = 2;
   bit          stray_en = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory model: one outstanding read, random stalls and latency
   initial begin
      bit          pend = 0;
      bit          hs = 0;
      logic [31:0] hs_addr = '0;
      logic [31:0] rd_addr = '0;
      int          cnt = 0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (hs) begin
            pend = 1;
            rd_addr = hs_addr;
            cnt = $urandom_range(max_lat, 0);
         end
         hs = 0;
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = $urandom;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rd(rd_addr);
               pend = 0;
            end else cnt--;
         end else if (stray_en && ($urandom % 3 == 0)) begin
            mem_rsp_valid = 1'b1;
         end
         mem_req_ready = !pend && ($urandom % 4 != 0);
         if (mem_req_valid && mem_req_ready) begin
            hs = 1;
            hs_addr = mem_req_addr;
            addr_log.push_back(mem_req_addr);
         end
      end
   end

   task automatic run_walk(input logic [31:0] va, input logic [31:0] root, input bit poke);
      logic [31:0] e1, e2, a1, a2, exp_pa;
      bit          exp_f, exp_l;
      int          exp_n, waited;
      a1 = root + (32'(va[31:22]) << 2);
      e1 = rd(a1);
      a2 = {e1[31:12], 12'h0} + (32'(va[21:12]) << 2);
      e2 = rd(a2);
      if (!e1[0]) begin
         exp_f = 1; exp_l = 0; exp_n = 1; exp_pa = 0;
      end else if (!e2[0]) begin
         exp_f = 1; exp_l = 1; exp_n = 2; exp_pa = 0;
      end else begin
         exp_f = 0; exp_l = 0; exp_n = 2; exp_pa = {e2[31:12], va[11:0]};
      end

      @(negedge clk);
      addr_log.delete();
      chk("R8", "ready while idle", 64'(req_ready), 64'd1);
      req_vaddr = va; root_base = root; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = $urandom;   // R2: later inputs must not matter
      root_base = $urandom;
      if (poke) begin
         chk("R8", "ready while busy", 64'(req_ready), 64'd0);
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      waited = 0;
      while (!rsp_valid && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      chk("R7", "response arrived", 64'(rsp_valid), 64'd1);
      chk(exp_f ? (exp_l ? "R6" : "R5") : "R4", "fault flag", 64'(rsp_fault), 64'(exp_f));
      chk(exp_f ? (exp_l ? "R6" : "R5") : "R4", "paddr", 64'(rsp_paddr), 64'(exp_pa));
      if (exp_f) chk(exp_l ? "R6" : "R5", "fault level", 64'(rsp_fault_lvl), 64'(exp_l));
      @(negedge clk);
      chk("R7", "pulse ended", 64'(rsp_valid), 64'd0);
      chk("R7", "ready after result", 64'(req_ready), 64'd1);
      chk(exp_f && !exp_l ? "R5" : "R10", "read count", 64'(addr_log.size()), 64'(exp_n));
      if (addr_log.size() >= 1) chk("R2", "outer entry address", 64'(addr_log[0]), 64'(a1));
      if (addr_log.size() >= 2 && exp_n == 2)
         chk("R3", "inner entry address", 64'(addr_log[1]), 64'(a2));
   endtask

   task automatic build(input logic [31:0] va, input logic [31:0] root,
                        input logic [19:0] f1, input bit v1,
                        input logic [19:0] f2, input bit v2);
      mem.delete();
      mem[root + (32'(va[31:22]) << 2)] = {f1, 11'($urandom), v1};
      mem[{f1, 12'h0} + (32'(va[21:12]) << 2)] = {f2, 11'($urandom), v2};
   endtask

   initial begin
      process::self().srandom(32'd20240611);
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; root_base = '0;
      repeat (3) @(negedge clk);
      chk("R11", "ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "ready after reset", 64'(req_ready), 64'd1);
      chk("R11", "mem request after reset", 64'(mem_req_valid), 64'd0);
      chk("R11", "response after reset", 64'(rsp_valid), 64'd0);

      // R1: lowest address, all-one target frame
      build(32'h0, 32'h0001_0000, 20'h00abc, 1, 20'hfffff, 1);
      run_walk(32'h0, 32'h0001_0000, 0);
      // R1: highest address, indices 1023 and full offset
      build(32'hffff_ffff, 32'h0002_0000, 20'h00123, 1, 20'h54321, 1);
      run_walk(32'hffff_ffff, 32'h0002_0000, 0);
      chk("R1", "top outer index address", 64'(addr_log[0]), 64'h0002_0ffc);
      chk("R1", "top inner index address", 64'(addr_log[1]), 64'h0012_3ffc);
      // R5: outer invalid with nonzero frame bits
      build(32'h1234_5678, 32'h0003_0000, 20'hfffff, 0, 20'h11111, 1);
      run_walk(32'h1234_5678, 32'h0003_0000, 0);
      // R6: inner invalid
      build(32'h8765_4321, 32'h0004_0000, 20'h00777, 1, 20'hfffff, 0);
      run_walk(32'h8765_4321, 32'h0004_0000, 0);
      // R8: request during a busy walk is ignored
      build(32'h0040_1abc, 32'h0005_0000, 20'h00888, 1, 20'h0abcd, 1);
      run_walk(32'h0040_1abc, 32'h0005_0000, 1);
      // R10: stray responses with long latency
      stray_en = 1'b1; max_lat = 6;
      for (int i = 0; i < 8; i++) begin
         logic [31:0] va = $urandom;
         build(va, 32'h0006_0000, 20'h00999 + 20'(i), 1, 20'($urandom), 1);
         run_walk(va, 32'h0006_0000, i[0]);
      end
      stray_en = 1'b0; max_lat = 2;
      // random walks
      for (int i = 0; i < 80; i++) begin
         logic [31:0] va   = $urandom;
         logic [31:0] root = {20'($urandom), 12'h0};
         logic [19:0] f1   = 20'($urandom);
         if (f1 == root[31:12]) f1 = f1 + 20'd1;
         max_lat = i % 5;
         stray_en = (i % 3 == 0);
         build(va, root, f1, 1'(($urandom % 8) != 0), 20'($urandom), 1'(($urandom % 8) != 0));
         run_walk(va, root, (i % 4 == 0));
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(10 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule